// File: doc/BRIEF.md
# Dual-Window Peripheral Register File

This block is the peripheral register file of a small 8-bit processor. The core reaches it through two address windows. A six-bit short I/O address serves the dedicated in/out operations and the single-bit set, clear and test operations. An eight-bit data-space address serves ordinary load/store. A data-space address equal to a short address plus 0x20 lands on the same register. An extended bank above the aliased window is reachable only through data space.

The file holds a control register, a status-flag register, three scratch registers, a mask register with only its low nibble implemented, and a parameterised bank of extended registers. Peripheral events arrive on a flag-set input vector. Software clears a flag by writing a 1 to its position. A bit-set on the flag register clears only the named flag and leaves its neighbours alone. Reads are combinational within the access cycle. Writes take effect on the rising clock edge. The asynchronous active-low reset is released through a two-stage synchroniser.

Top module: `iorf_dual_window`

## Requirements
- R1: After reset, every register reads 0x00.
- R2: `op_i` encodes 0 none, 1 short read, 2 short write, 3 data read, 4 data write, 5 bit set, 6 bit clear, 7 bit test. Short accesses use `addr_i[5:0]` and ignore `addr_i[7:6]`. The map is: control at short 0x03, flags at 0x04, scratch at 0x1E, 0x2A and 0x2B, and mask at 0x2C. `rdata_o` shows the selected register combinationally during a read and is 0x00 for every other operation. A write takes effect at the next rising edge.
- R3: A data access at address S+0x20, for data addresses 0x20 to 0x5F, reads and writes the same register as a short access at S.
- R4: The extended registers sit at data addresses 0x60 to 0x63 and are reached only by data read and write. A short access whose low six bits match never touches them.
- R5: Bit set and bit clear, with `addr_i` below 0x20 and bit `bit_i`, change only that bit of the control and scratch registers. With `addr_i` at 0x20 or above they have no effect.
- R6: A bit test with `addr_i` below 0x20 drives `tst_o` to the addressed bit in the same cycle. Above that range it drives 0. `tst_o` is 0 for every other operation.
- R7: In the flag register, writing a 1 to a bit clears that flag and writing a 0 leaves it unchanged. A bit set clears only the named flag. A bit clear has no effect.
- R8: A 1 on `evt_i[b]` sets flag b at the next edge. If a clear hits the same flag in the same cycle, the flag stays set.
- R9: The mask register stores only bits 3:0. Bits 7:4 read 0, and writes to them are ignored.
- R10: Unmapped addresses read 0x00 and writes to them have no effect. These are the reserved short addresses, data addresses below 0x20, and data addresses 0x64 to 0xFF.
- R11: The three scratch registers hold any byte value, including 0x00, 0xFF and 0xA5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 3 | Access type for this cycle |
| addr_i | input | 8 | Short or data-space address |
| bit_i | input | 3 | Bit index for single-bit operations |
| wdata_i | input | 8 | Write data |
| evt_i | input | 8 | Peripheral flag-set requests |
| rdata_o | output | 8 | Read data, combinational |
| tst_o | output | 1 | Bit-test result |

## Verification
The flag assertions assume that a write-one-to-clear or bit-set on the flag register happens while `evt_i` is zero, unless the cycle is meant to show that the set wins. The bench raises events only in dedicated cycles, plus one cycle that combines an event with a clear on purpose. The properties also assume that every input is stable from the falling edge to the next rising edge. The bench drives all inputs on the falling edge and returns `op_i` to none after each access, so no operation repeats across edges.

// File: rtl/iorf_pkg.sv
package iorf_pkg;

  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_IO_RD = 3'd1,
    OP_IO_WR = 3'd2,
    OP_DS_RD = 3'd3,
    OP_DS_WR = 3'd4,
    OP_BSET  = 3'd5,
    OP_BCLR  = 3'd6,
    OP_BTST  = 3'd7
  } iorf_op_e;

  typedef struct packed {
    logic rd;
    logic wr;
    logic bset;
    logic bclr;
    logic btst;
  } iorf_acc_t;

endpackage

// File: rtl/iorf_decode.sv
module iorf_decode
  import iorf_pkg::*;
#(
  parameter int AW       = 8,
  parameter int N_EXT    = 4,
  parameter int EXT_BASE = 'h60,
  parameter int A_CTL    = 'h03,
  parameter int A_FLG    = 'h04,
  parameter int A_GP0    = 'h1E,
  parameter int A_GP1    = 'h2A,
  parameter int A_GP2    = 'h2B,
  parameter int A_MSK    = 'h2C
) (
  input  logic [2:0]        op_i,
  input  logic [AW-1:0]     addr_i,
  output iorf_acc_t         acc_o,
  output logic              sel_ctl_o,
  output logic              sel_flg_o,
  output logic [2:0]        sel_gp_o,
  output logic              sel_msk_o,
  output logic [N_EXT-1:0]  sel_ext_o
);

  localparam int SW       = AW - 2;
  localparam int DS_OFS   = 1 << (SW - 1);
  localparam int DS_END   = DS_OFS + (1 << SW);
  localparam int BIT_LIM  = 1 << (SW - 1);
  localparam int A_GP [3] = '{A_GP0, A_GP1, A_GP2};

  iorf_op_e      op;
  logic          short_hit;
  logic [SW-1:0] sidx;
  logic          ds_acc;

  always_comb begin
    op        = iorf_op_e'(op_i);
    short_hit = 1'b0;
    sidx      = '0;
    ds_acc    = 1'b0;
    acc_o     = '0;
    unique case (op)
      OP_IO_RD, OP_IO_WR: begin
        short_hit = 1'b1;
        sidx      = addr_i[SW-1:0];
      end
      OP_DS_RD, OP_DS_WR: begin
        ds_acc = 1'b1;
        if (int'(addr_i) >= DS_OFS && int'(addr_i) < DS_END) begin
          short_hit = 1'b1;
          sidx      = SW'(int'(addr_i) - DS_OFS);
        end
      end
      OP_BSET, OP_BCLR, OP_BTST: begin
        if (int'(addr_i) < BIT_LIM) begin
          short_hit = 1'b1;
          sidx      = addr_i[SW-1:0];
        end
      end
      default: ;
    endcase
    acc_o.rd   = (op == OP_IO_RD) || (op == OP_DS_RD);
    acc_o.wr   = (op == OP_IO_WR) || (op == OP_DS_WR);
    acc_o.bset = (op == OP_BSET);
    acc_o.bclr = (op == OP_BCLR);
    acc_o.btst = (op == OP_BTST);
  end

  assign sel_ctl_o = short_hit && (sidx == SW'(A_CTL));
  assign sel_flg_o = short_hit && (sidx == SW'(A_FLG));
  assign sel_msk_o = short_hit && (sidx == SW'(A_MSK));

  for (genvar g = 0; g < 3; g++) begin : g_gp_sel
    assign sel_gp_o[g] = short_hit && (sidx == SW'(A_GP[g]));
  end

  for (genvar k = 0; k < N_EXT; k++) begin : g_ext_sel
    assign sel_ext_o[k] = ds_acc && (addr_i == AW'(EXT_BASE + k));
  end

endmodule

// File: rtl/iorf_regs.sv
module iorf_regs #(
  parameter int DW       = 8,
  parameter int N_EXT    = 4,
  parameter int MSK_BITS = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_i,
  input  logic                   bset_i,
  input  logic                   bclr_i,
  input  logic [$clog2(DW)-1:0]  bit_i,
  input  logic [DW-1:0]          wdata_i,
  input  logic [DW-1:0]          evt_i,
  input  logic                   sel_ctl_i,
  input  logic                   sel_flg_i,
  input  logic [2:0]             sel_gp_i,
  input  logic                   sel_msk_i,
  input  logic [N_EXT-1:0]       sel_ext_i,
  output logic [DW-1:0]          ctl_q,
  output logic [DW-1:0]          flg_q,
  output logic [3*DW-1:0]        gp_flat_o,
  output logic [DW-1:0]          msk_q,
  output logic [N_EXT*DW-1:0]    ext_flat_o
);

  localparam int N_GP = 3;

  logic [DW-1:0] bmask;
  assign bmask = DW'(1) << bit_i;

  function automatic logic [DW-1:0] f_next(input logic [DW-1:0] cur,
                                           input logic [DW-1:0] m,
                                           input logic [DW-1:0] w,
                                           input logic wr, input logic bs,
                                           input logic bc);
    if (wr)      return w;
    else if (bs) return cur | m;
    else if (bc) return cur & ~m;
    else         return cur;
  endfunction

  // control register
  logic          ctl_ce;
  logic [DW-1:0] ctl_d;
  always_comb begin
    ctl_ce = sel_ctl_i && (wr_i || bset_i || bclr_i);
    ctl_d  = f_next(ctl_q, bmask, wdata_i, wr_i, bset_i, bclr_i);
  end
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= '0;
    else if (ctl_ce) ctl_q <= ctl_d;
  end

  // status flags: write-one-to-clear, event set dominates
  logic [DW-1:0] clr_mask;
  logic          flg_ce;
  logic [DW-1:0] flg_d;
  always_comb begin
    clr_mask = '0;
    if (sel_flg_i) begin
      if (wr_i)        clr_mask = wdata_i;
      else if (bset_i) clr_mask = bmask;
    end
    flg_d  = (flg_q & ~clr_mask) | evt_i;
    flg_ce = (|clr_mask) || (|evt_i);
  end
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flg_q <= '0;
    else if (flg_ce) flg_q <= flg_d;
  end

  // scratch registers
  for (genvar g = 0; g < N_GP; g++) begin : g_gp
    logic          ce;
    logic [DW-1:0] d;
    logic [DW-1:0] q;
    always_comb begin
      ce = sel_gp_i[g] && (wr_i || bset_i || bclr_i);
      d  = f_next(q, bmask, wdata_i, wr_i, bset_i, bclr_i);
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (ce) q <= d;
    end
    assign gp_flat_o[g*DW +: DW] = q;
  end

  // mask register: only low MSK_BITS stored
  logic                msk_ce;
  logic [MSK_BITS-1:0] msk_r;
  always_comb msk_ce = sel_msk_i && wr_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      msk_r <= '0;
    else if (msk_ce) msk_r <= wdata_i[MSK_BITS-1:0];
  end
  assign msk_q = DW'(msk_r);

  // extended bank, data space only
  for (genvar k = 0; k < N_EXT; k++) begin : g_ext
    logic          ce;
    logic [DW-1:0] q;
    always_comb ce = sel_ext_i[k] && wr_i;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (ce) q <= wdata_i;
    end
    assign ext_flat_o[k*DW +: DW] = q;
  end

endmodule

// File: rtl/iorf_rdmux.sv
module iorf_rdmux #(
  parameter int DW    = 8,
  parameter int N_EXT = 4
) (
  input  logic                  rd_i,
  input  logic                  btst_i,
  input  logic [$clog2(DW)-1:0] bit_i,
  input  logic                  sel_ctl_i,
  input  logic                  sel_flg_i,
  input  logic [2:0]            sel_gp_i,
  input  logic                  sel_msk_i,
  input  logic [N_EXT-1:0]      sel_ext_i,
  input  logic [DW-1:0]         ctl_i,
  input  logic [DW-1:0]         flg_i,
  input  logic [3*DW-1:0]       gp_flat_i,
  input  logic [DW-1:0]         msk_i,
  input  logic [N_EXT*DW-1:0]   ext_flat_i,
  output logic [DW-1:0]         rdata_o,
  output logic                  tst_o
);

  logic [DW-1:0] val;

  always_comb begin
    val = ({DW{sel_ctl_i}} & ctl_i)
        | ({DW{sel_flg_i}} & flg_i)
        | ({DW{sel_msk_i}} & msk_i);
    for (int g = 0; g < 3; g++)
      val = val | ({DW{sel_gp_i[g]}} & gp_flat_i[g*DW +: DW]);
    for (int k = 0; k < N_EXT; k++)
      val = val | ({DW{sel_ext_i[k]}} & ext_flat_i[k*DW +: DW]);
    rdata_o = rd_i ? val : '0;
    tst_o   = btst_i && val[bit_i];
  end

endmodule

// File: rtl/iorf_dual_window.sv
module iorf_dual_window
  import iorf_pkg::*;
#(
  parameter int DW       = 8,
  parameter int AW       = 8,
  parameter int N_EXT    = 4,
  parameter int EXT_BASE = 'h60,
  parameter int MSK_BITS = 4,
  parameter int A_CTL    = 'h03,
  parameter int A_FLG    = 'h04,
  parameter int A_GP0    = 'h1E,
  parameter int A_GP1    = 'h2A,
  parameter int A_GP2    = 'h2B,
  parameter int A_MSK    = 'h2C
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [2:0]            op_i,
  input  logic [AW-1:0]         addr_i,
  input  logic [$clog2(DW)-1:0] bit_i,
  input  logic [DW-1:0]         wdata_i,
  input  logic [DW-1:0]         evt_i,
  output logic [DW-1:0]         rdata_o,
  output logic                  tst_o
);

  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_pipe;
  logic       rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];

  iorf_acc_t             acc;
  logic                  sel_ctl, sel_flg, sel_msk;
  logic [2:0]            sel_gp;
  logic [N_EXT-1:0]      sel_ext;
  logic [DW-1:0]         ctl_q, flg_q, msk_q;
  logic [3*DW-1:0]       gp_flat;
  logic [N_EXT*DW-1:0]   ext_flat;

  iorf_decode #(
    .AW(AW), .N_EXT(N_EXT), .EXT_BASE(EXT_BASE),
    .A_CTL(A_CTL), .A_FLG(A_FLG), .A_GP0(A_GP0), .A_GP1(A_GP1),
    .A_GP2(A_GP2), .A_MSK(A_MSK)
  ) u_dec (
    .op_i(op_i), .addr_i(addr_i), .acc_o(acc),
    .sel_ctl_o(sel_ctl), .sel_flg_o(sel_flg), .sel_gp_o(sel_gp),
    .sel_msk_o(sel_msk), .sel_ext_o(sel_ext)
  );

  iorf_regs #(.DW(DW), .N_EXT(N_EXT), .MSK_BITS(MSK_BITS)) u_regs (
    .clk(clk), .rst_n(rst_sn),
    .wr_i(acc.wr), .bset_i(acc.bset), .bclr_i(acc.bclr),
    .bit_i(bit_i), .wdata_i(wdata_i), .evt_i(evt_i),
    .sel_ctl_i(sel_ctl), .sel_flg_i(sel_flg), .sel_gp_i(sel_gp),
    .sel_msk_i(sel_msk), .sel_ext_i(sel_ext),
    .ctl_q(ctl_q), .flg_q(flg_q), .gp_flat_o(gp_flat),
    .msk_q(msk_q), .ext_flat_o(ext_flat)
  );

  iorf_rdmux #(.DW(DW), .N_EXT(N_EXT)) u_rd (
    .rd_i(acc.rd), .btst_i(acc.btst), .bit_i(bit_i),
    .sel_ctl_i(sel_ctl), .sel_flg_i(sel_flg), .sel_gp_i(sel_gp),
    .sel_msk_i(sel_msk), .sel_ext_i(sel_ext),
    .ctl_i(ctl_q), .flg_i(flg_q), .gp_flat_i(gp_flat),
    .msk_i(msk_q), .ext_flat_i(ext_flat),
    .rdata_o(rdata_o), .tst_o(tst_o)
  );

endmodule

// File: rtl/iorf_dual_window_chk.sv
module iorf_dual_window_chk
  import iorf_pkg::*;
#(
  parameter int DW    = 8,
  parameter int AW    = 8,
  parameter int N_EXT = 4,
  parameter int A_CTL = 'h03,
  parameter int A_FLG = 'h04
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [2:0]            op_i,
  input logic [AW-1:0]         addr_i,
  input logic [$clog2(DW)-1:0] bit_i,
  input logic [DW-1:0]         wdata_i,
  input logic [DW-1:0]         evt_i,
  input logic [DW-1:0]         rdata_o,
  input logic                  tst_o,
  input logic [DW-1:0]         ctl_q,
  input logic [DW-1:0]         flg_q,
  input logic [N_EXT*DW-1:0]   ext_flat
);

  logic [DW-1:0] bm;
  assign bm = DW'(1) << bit_i;

  a_r8_event_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_i) |=> ((flg_q & $past(evt_i)) == $past(evt_i)));

  a_r7_zero_write_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_IO_WR && addr_i[AW-3:0] == (AW-2)'(A_FLG) && wdata_i == '0 && evt_i == '0)
    |=> $stable(flg_q));

  a_r7_bitset_clears_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_BSET && addr_i == AW'(A_FLG) && evt_i == '0)
    |=> (flg_q == ($past(flg_q) & ~$past(bm))));

  a_r5_bitset_single_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_BSET && addr_i == AW'(A_CTL))
    |=> (ctl_q == ($past(ctl_q) | $past(bm))));

  a_r4_short_write_skips_ext: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_IO_WR) |=> $stable(ext_flat));

  a_r6_test_output_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i != OP_BTST) |-> !tst_o);

  a_r10_low_data_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_DS_RD && int'(addr_i) < 'h20) |-> (rdata_o == '0));

endmodule

bind iorf_dual_window iorf_dual_window_chk #(
  .DW(DW), .AW(AW), .N_EXT(N_EXT), .A_CTL(A_CTL), .A_FLG(A_FLG)
) u_chk (
  .clk(clk), .rst_n(rst_sn), .op_i(op_i), .addr_i(addr_i), .bit_i(bit_i),
  .wdata_i(wdata_i), .evt_i(evt_i), .rdata_o(rdata_o), .tst_o(tst_o),
  .ctl_q(ctl_q), .flg_q(flg_q), .ext_flat(ext_flat)
);

// File: tb/iorf_dual_window_bench.sv
module iorf_dual_window_bench;

  localparam int CLK_P = 10;

  localparam logic [2:0] NONE = 3'd0, IORD = 3'd1, IOWR = 3'd2, DSRD = 3'd3,
                         DSWR = 3'd4, BSET = 3'd5, BCLR = 3'd6, BTST = 3'd7;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] op_i;
  logic [7:0] addr_i;
  logic [2:0] bit_i;
  logic [7:0] wdata_i;
  logic [7:0] evt_i;
  logic [7:0] rdata_o;
  logic       tst_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  iorf_dual_window u_iorf_dual_window (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .addr_i(addr_i), .bit_i(bit_i),
    .wdata_i(wdata_i), .evt_i(evt_i), .rdata_o(rdata_o), .tst_o(tst_o)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  // one access with side effects; done once the following falling edge is reached
  task automatic acc(input logic [2:0] op, input logic [7:0] a, input logic [2:0] b,
                     input logic [7:0] d, input logic [7:0] e);
    @(negedge clk);
    op_i = op; addr_i = a; bit_i = b; wdata_i = d; evt_i = e;
    @(negedge clk);
    op_i = NONE; evt_i = '0;
  endtask

  task automatic rd(input logic [2:0] op, input logic [7:0] a, input logic [2:0] b,
                    output logic [7:0] d, output logic t);
    @(negedge clk);
    op_i = op; addr_i = a; bit_i = b;
    #2;
    d = rdata_o; t = tst_o;
    op_i = NONE;
  endtask

  task automatic rchk(input string req, input logic [2:0] op, input logic [7:0] a,
                      input logic [7:0] exp);
    logic [7:0] d;
    logic t;
    rd(op, a, 3'd0, d, t);
    chk(req, d, exp);
  endtask

  task automatic t_reset;
    rchk("R1 ctl", IORD, 8'h03, 8'h00);
    rchk("R1 flg", IORD, 8'h04, 8'h00);
    rchk("R1 gp0", IORD, 8'h1E, 8'h00);
    rchk("R1 ext0", DSRD, 8'h60, 8'h00);
  endtask

  task automatic t_io_rw;
    acc(IOWR, 8'h03, 3'd0, 8'h5A, 8'h00);
    rchk("R2 short read", IORD, 8'h03, 8'h5A);
    rchk("R2 upper addr bits ignored", IORD, 8'hC3, 8'h5A);
    rchk("R2 idle rdata zero", NONE, 8'h03, 8'h00);
  endtask

  task automatic t_alias;
    acc(DSWR, 8'h3E, 3'd0, 8'h3C, 8'h00);
    rchk("R3 data write seen at short", IORD, 8'h1E, 8'h3C);
    acc(IOWR, 8'h2A, 3'd0, 8'h77, 8'h00);
    rchk("R3 short write seen at data", DSRD, 8'h4A, 8'h77);
  endtask

  task automatic t_ext;
    acc(DSWR, 8'h61, 3'd0, 8'h99, 8'h00);
    rchk("R4 ext data rw", DSRD, 8'h61, 8'h99);
    acc(IOWR, 8'h61, 3'd0, 8'h11, 8'h00);
    rchk("R4 short write misses ext", DSRD, 8'h61, 8'h99);
    rchk("R4 short read misses ext", IORD, 8'h61, 8'h00);
  endtask

  task automatic t_bitops;
    acc(IOWR, 8'h03, 3'd0, 8'h00, 8'h00);
    acc(BSET, 8'h03, 3'd3, 8'hFF, 8'h00);
    rchk("R5 set bit3", IORD, 8'h03, 8'h08);
    acc(BSET, 8'h03, 3'd7, 8'h00, 8'h00);
    rchk("R5 set bit7", IORD, 8'h03, 8'h88);
    acc(BCLR, 8'h03, 3'd3, 8'hFF, 8'h00);
    rchk("R5 clear bit3", IORD, 8'h03, 8'h80);
    acc(BCLR, 8'h2A, 3'd0, 8'h00, 8'h00);
    rchk("R5 bit op above 0x1F ignored", IORD, 8'h2A, 8'h77);
  endtask

  task automatic t_test;
    logic [7:0] d;
    logic t;
    rd(BTST, 8'h03, 3'd7, d, t);
    chk("R6 test set bit", {7'd0, t}, 8'h01);
    rd(BTST, 8'h03, 3'd0, d, t);
    chk("R6 test clear bit", {7'd0, t}, 8'h00);
    rd(BTST, 8'h2A, 3'd0, d, t);
    chk("R6 test above 0x1F", {7'd0, t}, 8'h00);
    rd(IORD, 8'h03, 3'd7, d, t);
    chk("R6 no test on read", {7'd0, t}, 8'h00);
  endtask

  task automatic t_w1c;
    acc(NONE, 8'h00, 3'd0, 8'h00, 8'hFF);
    rchk("R7 flags raised", IORD, 8'h04, 8'hFF);
    acc(IOWR, 8'h04, 3'd0, 8'h00, 8'h00);
    rchk("R7 zero write keeps", IORD, 8'h04, 8'hFF);
    acc(IOWR, 8'h04, 3'd0, 8'h81, 8'h00);
    rchk("R7 one clears", IORD, 8'h04, 8'h7E);
    acc(BSET, 8'h04, 3'd1, 8'h00, 8'h00);
    rchk("R7 bit set clears only bit1", IORD, 8'h04, 8'h7C);
    acc(BCLR, 8'h04, 3'd2, 8'h00, 8'h00);
    rchk("R7 bit clear no effect", IORD, 8'h04, 8'h7C);
    acc(DSWR, 8'h24, 3'd0, 8'h0C, 8'h00);
    rchk("R7 data window clear", IORD, 8'h04, 8'h70);
  endtask

  task automatic t_setwins;
    acc(IOWR, 8'h04, 3'd0, 8'h30, 8'h10);
    rchk("R8 set beats clear", IORD, 8'h04, 8'h50);
    acc(NONE, 8'h00, 3'd0, 8'h00, 8'h01);
    rchk("R8 event alone", IORD, 8'h04, 8'h51);
  endtask

  task automatic t_msk;
    acc(IOWR, 8'h2C, 3'd0, 8'hFF, 8'h00);
    rchk("R9 upper bits zero", IORD, 8'h2C, 8'h0F);
    acc(DSWR, 8'h4C, 3'd0, 8'hA6, 8'h00);
    rchk("R9 low nibble only", DSRD, 8'h4C, 8'h06);
  endtask

  task automatic t_unmapped;
    acc(IOWR, 8'h00, 3'd0, 8'hFF, 8'h00);
    rchk("R10 reserved short", IORD, 8'h00, 8'h00);
    acc(DSWR, 8'h10, 3'd0, 8'hFF, 8'h00);
    rchk("R10 low data", DSRD, 8'h10, 8'h00);
    acc(DSWR, 8'h64, 3'd0, 8'h55, 8'h00);
    rchk("R10 above ext", DSRD, 8'h64, 8'h00);
    rchk("R10 ext0 untouched", DSRD, 8'h60, 8'h00);
    rchk("R10 ext3 untouched", DSRD, 8'h63, 8'h00);
    acc(BSET, 8'h05, 3'd2, 8'h00, 8'h00);
    rchk("R10 bit op reserved", IORD, 8'h05, 8'h00);
    rchk("R10 ctl untouched", IORD, 8'h03, 8'h80);
  endtask

  task automatic t_gp;
    acc(IOWR, 8'h1E, 3'd0, 8'hFF, 8'h00);
    acc(DSWR, 8'h4A, 3'd0, 8'h00, 8'h00);
    acc(IOWR, 8'h2B, 3'd0, 8'hA5, 8'h00);
    rchk("R11 gp0 0xFF", DSRD, 8'h3E, 8'hFF);
    rchk("R11 gp1 0x00", IORD, 8'h2A, 8'h00);
    rchk("R11 gp2 0xA5", DSRD, 8'h4B, 8'hA5);
  endtask

  initial begin
    rst_n = 1'b0; op_i = NONE; addr_i = '0; bit_i = '0; wdata_i = '0; evt_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_io_rw();
    t_alias();
    t_ext();
    t_bitops();
    t_test();
    t_w1c();
    t_setwins();
    t_msk();
    t_unmapped();
    t_gp();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule